// File: doc/BRIEF.md
# Phase-Adjustable Carrier Divider

This block divides an external carrier clock by a programmable ratio and produces two related square-wave outputs whose position relative to the count can be shifted. The carrier is not used as a clock. The block's own clock samples it through a synchronizer. Each rising edge that is detected advances an up-counter. The counter returns to zero after it reaches the divider value.

Output A goes high when the counter reaches a compare point RA and goes low when it reaches the divider value RC. A rising edge of output A is fed straight back as a trigger that raises output B. Output B goes low when the counter reaches a second compare point RB.

Both compare points come from a single phase offset. A host sets the divider and nudges the offset through a small write port. Nothing counts until the host issues an enable strobe. New settings are copied into the active compare set only when the counter wraps, so a running waveform never sees a half-updated set.

Top module: `carrier_phase_divider`

## Requirements
- R1: After reset, both outputs are low, the divider is 128 and the phase offset is 0. Once enabled, output A first rises on the 64th carrier rising edge.
- R2: Before the first `clkEnCmd` strobe, the counter stays at zero, both outputs stay low and carrier edges are ignored. After the strobe the block stays enabled until reset.
- R3: Each rising carrier edge advances the counter by exactly one, and falling edges do not advance it. From the divider value D, the next step returns the counter to 0, so one output period is D+1 carrier edges.
- R4: Output A rises on the step that brings the counter to RA and falls on the step that brings it to D.
- R5: Output B rises in the same cycle as a rising edge of output A and falls on the step that brings the counter to RB. A falling edge of output A leaves B unchanged.
- R6: The compare points are RA = (D/2 + off) mod D and RB = off mod D.
  - A write with `wrSel`=0 loads D from `wrData` (values below 2 become 2) and sets off to 0.
  - A write with `wrSel`=1 adds `wrData`, taken as a signed two's-complement increment, to off modulo D.
- R7: Values written to the divider or the phase offset take effect only on the step that returns the counter to 0. Until then, the step that wraps the counter still uses the previous compare set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkEnCmd | input | 1 | One-cycle strobe that starts the channel |
| wrEn | input | 1 | Write strobe for the setting port |
| wrSel | input | 1 | 0 selects the divider, 1 selects the phase increment |
| wrData | input | 16 | Divider value or signed phase increment |
| carrierIn | input | 1 | External carrier, asynchronous to clk |
| outA | output | 1 | Output A (set at RA, cleared at D) |
| outB | output | 1 | Output B (set by rising edge of A, cleared at RB) |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a two-stage synchronizer and a reset divider of 128. It runs one full period at the reset divider to confirm where A rises and how the counter wraps. It then writes a divider of 8, so every output transition is reached within a few carrier edges. With the short period, a positive phase step, a negative step that wraps modulo the divider, and a divider rewrite that clears the offset can each be followed across the wrap that applies them.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  typedef struct packed {
    logic tick;
    logic enabled;
  } cpdStrobe_t;

  typedef enum logic {
    SEL_DIV   = 1'b0,
    SEL_PHASE = 1'b1
  } cpdSel_e;

endpackage

// File: rtl/cpd_ctrl.sv
module cpd_ctrl
  import cpd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_DIV   = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnCmd,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             carrierIn,
  output cpdStrobe_t       strobes,
  output logic [CNT_W-1:0] divPend,
  output logic [CNT_W-1:0] raPend,
  output logic [CNT_W-1:0] rbPend
);

  localparam int SW = CNT_W + 2;
  localparam logic [CNT_W-1:0] MIN_DIV = CNT_W'(2);
  localparam logic [CNT_W-1:0] RST_DIV = CNT_W'(RESET_DIV);

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic enabled;
  logic [CNT_W-1:0] offPend;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= carrierIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], carrierIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= 1'b0;
      enabled <= 1'b0;
    end else begin
      prevQ <= syncQ[SYNC_STAGES-1];
      if (clkEnCmd) enabled <= 1'b1;
    end
  end

  assign strobes.enabled = enabled;
  assign strobes.tick    = enabled & syncQ[SYNC_STAGES-1] & ~prevQ;

  logic signed [SW-1:0] sumS, divS, remS, fixS;
  logic [CNT_W-1:0] newOff, divIn;

  always_comb begin
    sumS   = $signed({2'b00, offPend}) + $signed({{2{wrData[CNT_W-1]}}, wrData});
    divS   = $signed({2'b00, divPend});
    remS   = sumS % divS;
    fixS   = (remS < 0) ? remS + divS : remS;
    newOff = fixS[CNT_W-1:0];
    divIn  = (wrData < MIN_DIV) ? MIN_DIV : wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divPend <= RST_DIV;
      offPend <= '0;
    end else if (wrEn) begin
      if (cpdSel_e'(wrSel) == SEL_DIV) begin
        divPend <= divIn;
        offPend <= '0;
      end else begin
        offPend <= newOff;
      end
    end
  end

  logic [CNT_W:0] raSum, raWrap;

  always_comb begin
    raSum  = {1'b0, divPend >> 1} + {1'b0, offPend};
    raWrap = raSum - {1'b0, divPend};
    raPend = (raSum >= {1'b0, divPend}) ? raWrap[CNT_W-1:0] : raSum[CNT_W-1:0];
    rbPend = offPend;
  end

  // R6
  offset_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    offPend < divPend);

  // R3
  single_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick |=> !strobes.tick);

  // R2
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    enabled |=> enabled);

endmodule

// File: rtl/cpd_datapath.sv
module cpd_datapath
  import cpd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RESET_DIV = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  cpdStrobe_t       strobes,
  input  logic [CNT_W-1:0] divPend,
  input  logic [CNT_W-1:0] raPend,
  input  logic [CNT_W-1:0] rbPend,
  output logic             outA,
  output logic             outB
);

  localparam logic [CNT_W-1:0] RST_DIV = CNT_W'(RESET_DIV);
  localparam logic [CNT_W-1:0] RST_RA  = CNT_W'(RESET_DIV / 2);

  logic [CNT_W-1:0] cnt, rcAct, raAct, rbAct, nextCnt;
  logic wrap, raHit, rbHit, rcHit, aNext, bNext, trig;

  always_comb begin
    wrap    = (cnt == rcAct);
    nextCnt = wrap ? '0 : cnt + 1'b1;
    raHit   = (nextCnt == raAct);
    rbHit   = (nextCnt == rbAct);
    rcHit   = (nextCnt == rcAct);
    if (rcHit)      aNext = 1'b0;
    else if (raHit) aNext = 1'b1;
    else            aNext = outA;
    trig = aNext & ~outA;
    if (rbHit)     bNext = 1'b0;
    else if (trig) bNext = 1'b1;
    else           bNext = outB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      outA  <= 1'b0;
      outB  <= 1'b0;
      rcAct <= RST_DIV;
      raAct <= RST_RA;
      rbAct <= '0;
    end else if (!strobes.enabled) begin
      cnt   <= '0;
      outA  <= 1'b0;
      outB  <= 1'b0;
      rcAct <= divPend;
      raAct <= raPend;
      rbAct <= rbPend;
    end else if (strobes.tick) begin
      cnt  <= nextCnt;
      outA <= aNext;
      outB <= bNext;
      if (wrap) begin
        rcAct <= divPend;
        raAct <= raPend;
        rbAct <= rbPend;
      end
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.enabled |-> (cnt == '0) && !outA && !outB);

  // R3
  count_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.enabled && !strobes.tick) |=> $stable(cnt));

  // R4
  a_rise_point_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outA) |-> cnt == $past(raAct));

  // R4
  a_fall_point_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outA) |-> cnt == $past(rcAct));

  // R5
  b_follows_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outB) |-> $rose(outA));

  // R7
  defer_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.enabled && strobes.tick && (cnt != rcAct)) |=>
      $stable(rcAct) && $stable(raAct) && $stable(rbAct));

endmodule

// File: rtl/carrier_phase_divider.sv
module carrier_phase_divider
  import cpd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_DIV   = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnCmd,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             carrierIn,
  output logic             outA,
  output logic             outB
);

  cpdStrobe_t strobes;
  logic [CNT_W-1:0] divPend, raPend, rbPend;

  cpd_ctrl #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .RESET_DIV(RESET_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnCmd(clkEnCmd), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .carrierIn(carrierIn),
    .strobes(strobes), .divPend(divPend), .raPend(raPend), .rbPend(rbPend)
  );

  cpd_datapath #(
    .CNT_W(CNT_W), .RESET_DIV(RESET_DIV)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .divPend(divPend),
    .raPend(raPend), .rbPend(rbPend), .outA(outA), .outB(outB)
  );

endmodule

// File: tb/carrier_phase_divider_tb.sv
`timescale 1ns/1ps
module carrier_phase_divider_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEnCmd = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic carrierIn = 1'b0;
  logic outA, outB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  carrier_phase_divider u_dut (
    .clk(clk), .rstN(rstN), .clkEnCmd(clkEnCmd), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .carrierIn(carrierIn),
    .outA(outA), .outB(outB)
  );

  // Divider 8, offset 0: RA=4, RB=0. Expected {A,B} after each single edge,
  // counter going 1..8, 0, 1.
  localparam logic [1:0] VEC [10] = '{
    2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b01, 2'b00, 2'b00
  };

  task automatic chk(input logic expA, input logic expB, input string tag);
    checks++;
    if (outA !== expA || outB !== expB) begin
      fails++;
      $display("FAIL %s: got A=%0b B=%0b expected A=%0b B=%0b",
               tag, outA, outB, expA, expB);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) carrierIn = 1'b1;
      repeat (3) @(negedge clk);
      carrierIn = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    chk(0, 0, "R1 reset outputs");

    pulses(5);
    chk(0, 0, "R2 edges before enable");

    @(negedge clk) clkEnCmd = 1'b1;
    @(negedge clk) clkEnCmd = 1'b0;
    pulses(63);
    chk(0, 0, "R1 R3 count 63");
    pulses(1);
    chk(1, 1, "R1 R4 R5 count 64");
    pulses(63);
    chk(1, 1, "R4 count 127");
    pulses(1);
    chk(0, 1, "R4 R5 fall of A ignored at 128");
    pulses(1);
    chk(0, 0, "R3 R5 wrap clears B at 0");

    writeReg(1'b0, 16'd8);
    pulses(4);
    chk(0, 0, "R7 new divider not used mid-period");
    pulses(60);
    chk(1, 1, "R7 old RA still active");
    pulses(64);
    chk(0, 1, "R7 old RC still active");
    pulses(1);
    chk(0, 0, "R7 wrap loads divider 8");

    for (int i = 0; i < 10; i++) begin
      pulses(1);
      chk(VEC[i][1], VEC[i][0], $sformatf("R3 R4 R5 R6 table row %0d", i));
    end

    writeReg(1'b1, 16'd3);
    pulses(7);
    chk(0, 1, "R7 phase deferred, count 8");
    pulses(1);
    chk(0, 0, "R7 phase applied at wrap");
    pulses(6);
    chk(0, 0, "R6 RA moved past 6");
    pulses(1);
    chk(1, 1, "R6 RA=7");
    pulses(1);
    chk(0, 1, "R4 fall at 8");
    pulses(3);
    chk(0, 1, "R6 RB=3 not yet reached");
    pulses(1);
    chk(0, 0, "R6 RB=3 clears B");

    writeReg(1'b1, 16'hFFFB);
    pulses(4);
    chk(1, 1, "R7 old RA=7 after negative step");
    pulses(1);
    chk(0, 1, "R4 fall at 8");
    pulses(1);
    chk(0, 1, "R7 old RB kept on wrap step");
    pulses(1);
    chk(0, 1, "R6 count 1");
    pulses(1);
    chk(1, 1, "R6 negative wrap RA=2");
    pulses(4);
    chk(1, 0, "R6 RB=6 clears B while A high");
    pulses(2);
    chk(0, 0, "R4 fall at 8");

    writeReg(1'b0, 16'd8);
    pulses(1);
    chk(0, 0, "R6 divider rewrite wrap");
    pulses(4);
    chk(1, 1, "R6 divider write clears offset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule